// File: doc/BRIEF.md
# One-Hot Select Word Multiplexer

This block steers one of several equal-width data words to its output. A one-hot select vector chooses the word. When no select line is raised, a separate fallback word passes through instead. The block has no clock and no state, so the output follows the inputs within the same time step.

The candidate words arrive on one packed bus. Word `n` occupies bits `[n*WIDTH +: WIDTH]`, so word 0 sits in the least significant bits. Two parameters set the size: `WIDTH` is the word width and `S_WIDTH` is the number of select lines. The caller must keep the select one-hot or all-zero. When two or more select bits are high, the output is unspecified. The block neither detects nor resolves that case, and it has no priority logic.

Top module: `onehot_pmux`

## Requirements
- R1: When every bit of `s` is 0, `y` equals `a`.
- R2: When only bit `n` of `s` is set, `y` equals `b[n*WIDTH +: WIDTH]`. Word 0 is the least significant slice of `b`.
- R3: The lowest lane (n = 0) and the highest lane (n = S_WIDTH-1) select their own slice and not a neighbouring one.
- R4: While any single select bit is set, changing `a` has no effect on `y`.
- R5: While lane `n` is selected, changing any slice of `b` other than slice `n` has no effect on `y`.
- R6: `y` settles to its new value in the same time step as an input change, with no clock edge between them.
- R7: With `S_WIDTH` = 1, the block acts as a two-way choice. `s` = 0 gives `a` and `s` = 1 gives `b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Fallback word, passed on when no select bit is high |
| b | input | WIDTH*S_WIDTH | Packed candidate words, word n at bits [n*WIDTH +: WIDTH] |
| s | input | S_WIDTH | One-hot select; all-zero picks the fallback |
| y | output | WIDTH | Chosen word |

## Verification
The bench goes after the slice arithmetic. It selects the first and last lanes with all-ones neighbours and a zero target, so an off-by-one slice offset or reversed lane order shows up as ones leaking into `y`. It toggles `a` while a lane is selected and toggles every unselected slice. A fallback path that stays enabled, or a mask that fails to gate a lane, then corrupts `y` by ORing in the stray bits. A second instance with a single select line checks that the default and the one lane do not collapse when the generate structure is at its smallest.

// File: rtl/onehot_pmux_pkg.sv
package onehot_pmux_pkg;

  // Lowest bit position of lane n inside the packed candidate bus.
  function automatic int slice_lo(input int lane, input int word_w);
    return lane * word_w;
  endfunction

endpackage

// File: rtl/pmux_lane_gate.sv
module pmux_lane_gate #(
  parameter int WIDTH = 8
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] masked,
  output logic             active
);

  // Replicate the select bit across the word and AND it in.
  assign masked = word & {WIDTH{sel}};
  assign active = sel;

endmodule

// File: rtl/pmux_default_gate.sv
module pmux_default_gate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] word,
  input  logic             block,
  output logic [WIDTH-1:0] out,
  output logic             active
);

  assign active = ~block;
  assign out    = word & {WIDTH{active}};

endmodule

// File: rtl/pmux_or_tree.sv
module pmux_or_tree #(
  parameter int WIDTH = 8,
  parameter int LANES = 4
) (
  input  logic [WIDTH*LANES-1:0] bus,
  output logic [WIDTH-1:0]       merged
);

  generate
    if (LANES == 1) begin : g_single
      assign merged = bus;
    end else begin : g_multi
      always_comb begin
        merged = '0;
        for (int n = 0; n < LANES; n++) begin
          merged = merged | bus[n*WIDTH +: WIDTH];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/onehot_pmux.sv
module onehot_pmux
  import onehot_pmux_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int S_WIDTH = 4
) (
  input  logic [WIDTH-1:0]         a,
  input  logic [WIDTH*S_WIDTH-1:0] b,
  input  logic [S_WIDTH-1:0]       s,
  output logic [WIDTH-1:0]         y
);

  localparam int BUS_W = WIDTH * S_WIDTH;

  logic [BUS_W-1:0]   masked_bus;
  logic [S_WIDTH-1:0] lane_active;
  logic [WIDTH-1:0]   lanes_merged;
  logic [WIDTH-1:0]   dflt_word;
  logic               dflt_active;
  logic               any_sel;

  assign any_sel = |s;

  generate
    for (genvar n = 0; n < S_WIDTH; n++) begin : g_lane
      pmux_lane_gate #(.WIDTH(WIDTH)) u_gate (
        .sel    (s[n]),
        .word   (b[n*WIDTH +: WIDTH]),
        .masked (masked_bus[n*WIDTH +: WIDTH]),
        .active (lane_active[n])
      );
    end
  endgenerate

  pmux_or_tree #(.WIDTH(WIDTH), .LANES(S_WIDTH)) u_tree (
    .bus    (masked_bus),
    .merged (lanes_merged)
  );

  pmux_default_gate #(.WIDTH(WIDTH)) u_dflt (
    .word   (a),
    .block  (any_sel),
    .out    (dflt_word),
    .active (dflt_active)
  );

  assign y = lanes_merged | dflt_word;

  // Checks apply only to legal (one-hot or zero) and fully known selects.
  always_comb begin
    logic [WIDTH-1:0] picked;
    picked = a;
    for (int n = 0; n < S_WIDTH; n++) begin
      if (s[n]) picked = b[slice_lo(n, WIDTH) +: WIDTH];
    end
    if (!$isunknown({a, b, s}) && $onehot0(s)) begin
      assert_default_pass_R1: assert (s != '0 || y == a)
        else $error("fallback word not passed");
      assert_lane_pick_R2: assert (y == picked)
        else $error("wrong slice on output");
      assert_a_blocked_R4: assert (s == '0 || y == lanes_merged)
        else $error("fallback leaks into selected output");
      assert_one_source_R5: assert ($countones({dflt_active, lane_active}) == 1)
        else $error("not exactly one source enabled");
    end
  end

endmodule

// File: tb/test_onehot_pmux.sv
module test_onehot_pmux;

  localparam int W  = 8;
  localparam int SW = 4;
  localparam int W1 = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]    a;
  logic [W*SW-1:0] b;
  logic [SW-1:0]   s;
  logic [W-1:0]    y;

  logic [W1-1:0] a1, b1, y1;
  logic          s1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  onehot_pmux #(.WIDTH(W), .S_WIDTH(SW)) i_onehot_pmux (
    .a(a), .b(b), .s(s), .y(y)
  );

  onehot_pmux #(.WIDTH(W1), .S_WIDTH(1)) i_onehot_pmux_one (
    .a(a1), .b(b1), .s(s1), .y(y1)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] fa,
                                         input logic [W*SW-1:0] fb,
                                         input logic [SW-1:0] fs);
    logic [W-1:0] r;
    r = fa;
    for (int k = 0; k < SW; k++) if (fs[k]) r = fb[k*W +: W];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] na, input logic [W*SW-1:0] nb,
                       input logic [SW-1:0] ns);
    @(negedge clk);
    a = na; b = nb; s = ns;
    #2;
  endtask

  task automatic t_start;
    apply('0, '0, '0);
    chk("R1 initial", 32'(y), 32'h0);
  endtask

  task automatic t_default;
    for (int i = 0; i < 6; i++) begin
      apply(W'($urandom), (W*SW)'({$urandom, $urandom}), '0);
      chk("R1", 32'(y), 32'(a));
    end
  endtask

  task automatic t_each_lane;
    for (int r = 0; r < 3; r++) begin
      for (int n = 0; n < SW; n++) begin
        apply(W'($urandom), (W*SW)'({$urandom, $urandom}), SW'(1) << n);
        chk("R2", 32'(y), 32'(model(a, b, s)));
        chk("R2 slice", 32'(y), 32'(b[n*W +: W]));
      end
    end
  endtask

  task automatic t_edges;
    logic [W*SW-1:0] pat;
    pat = '1;
    pat[W-1:0] = '0;
    apply('1, pat, SW'(1));
    chk("R3 lane0", 32'(y), 32'h0);
    pat = '1;
    pat[(SW-1)*W +: W] = '0;
    apply('1, pat, SW'(1) << (SW-1));
    chk("R3 top lane", 32'(y), 32'h0);
    pat = '0;
    pat[(SW-1)*W +: W] = 8'hA5;
    apply('0, pat, SW'(1) << (SW-1));
    chk("R3 top value", 32'(y), 32'hA5);
  endtask

  task automatic t_ignore_a;
    logic [W*SW-1:0] pb;
    pb = (W*SW)'({$urandom, $urandom});
    for (int n = 0; n < SW; n++) begin
      apply('0, pb, SW'(1) << n);
      apply('1, pb, SW'(1) << n);
      chk("R4", 32'(y), 32'(pb[n*W +: W]));
      apply(W'($urandom), pb, SW'(1) << n);
      chk("R4", 32'(y), 32'(pb[n*W +: W]));
    end
  endtask

  task automatic t_ignore_others;
    logic [W*SW-1:0] pb;
    for (int n = 0; n < SW; n++) begin
      pb = '1;
      pb[n*W +: W] = 8'h3C;
      apply('0, pb, SW'(1) << n);
      chk("R5 ones around", 32'(y), 32'h3C);
      pb = '0;
      pb[n*W +: W] = 8'h3C;
      apply('0, pb, SW'(1) << n);
      chk("R5 zeros around", 32'(y), 32'h3C);
    end
  endtask

  task automatic t_comb;
    @(negedge clk);
    a = 8'h11; b = {8'h44, 8'h33, 8'h22, 8'h55}; s = 4'b0000;
    #1;
    chk("R6 default", 32'(y), 32'h11);
    s = 4'b0100;
    #1;
    chk("R6 switch", 32'(y), 32'h33);
    b[2*W +: W] = 8'h99;
    #1;
    chk("R6 data", 32'(y), 32'h99);
  endtask

  task automatic t_single;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      a1 = W1'($urandom); b1 = W1'($urandom); s1 = 1'b0;
      #2;
      chk("R7 default", 32'(y1), 32'(a1));
      s1 = 1'b1;
      #2;
      chk("R7 lane", 32'(y1), 32'(b1));
    end
  endtask

  initial begin
    a = '0; b = '0; s = '0;
    a1 = '0; b1 = '0; s1 = 1'b0;
    t_start();
    t_default();
    t_each_lane();
    t_edges();
    t_ignore_a();
    t_ignore_others();
    t_comb();
    t_single();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule